// File: doc/BRIEF.md
# Fixed-Ratio Pulse Divider

This block counts rising edges of a pulse train that arrives from outside the system clock domain. It emits one pulse, one system clock wide, for every `DIV_N` such edges. `DIV_N` is an elaboration-time constant and cannot be changed while the block runs. The input first crosses into the clock domain through a flop chain. Rising edges are then detected by comparing each synchronised sample with the one before it.

A parameter chooses how the terminal count is found:
- an up-counter compared for equality with `DIV_N`;
- a down-counter compared against zero;
- a down-counter one bit wider than `DIV_N-1` requires, whose top bit serves as the terminal flag with no comparator at all.

All three choices produce the same output, cycle for cycle. The choice changes only the logic that builds the terminal flag.

Top module: `pulse_divider`

## Requirements
- R1: While `rst_n` is low, `div_pulse` is 0. After reset is released, the first `div_pulse` comes after exactly `DIV_N` detected rising edges of `pulse_in`. A reset given in the middle of a run discards any partial count.
- R2: The count advances only on a detected rising edge of `pulse_in`. A steady high level, a steady low level, or a falling edge leaves the count unchanged.
- R3: `div_pulse` is high for exactly one clock cycle. If `pulse_in` rises and is sampled at clock edge k, and that rise completes a group of `DIV_N`, then `div_pulse` is high in the cycle that follows clock edge k+2.
- R4: Over any run started from reset, the number of `div_pulse` cycles equals floor(E / `DIV_N`), where E is the number of rising edges of `pulse_in`.
- R5: With `STYLE` = `STYLE_UP`, the counter starts at 0 and adds 1 on each edge. When the new value equals `DIV_N`, it returns to 0 and the pulse fires.
- R6: With `STYLE` = `STYLE_DOWN`, the counter starts at `DIV_N` and subtracts 1 on each edge. When the new value is 0, it is reloaded with `DIV_N` and the pulse fires.
- R7: With `STYLE` = `STYLE_SIGN`, the counter has $clog2(`DIV_N`)+1 bits and starts at `DIV_N-1` with its top bit clear. It subtracts 1 on each edge. The top bit turning to 1 fires the pulse and reloads `DIV_N-1`. No compare is used.
- R8: All three styles give identical `div_pulse` waveforms for the same input and reset.
- R9: A `DIV_N` below 2 is rejected at elaboration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released in step with `clk` |
| pulse_in | input | 1 | Pulse train to divide; may be asynchronous to `clk` |
| div_pulse | output | 1 | One-cycle pulse for every `DIV_N` input rising edges |

## Verification
A rise of `pulse_in` sampled at clock edge k is seen by the counter on edge k+2. Any pulse it causes is visible from just after edge k+2 until edge k+3. The bench drives `pulse_in` at falling clock edges. It models the input as a 2-cycle delay line plus an edge count, and compares every output at the following falling edge, so each compare falls exactly within the cycle in which the pulse is due. The three styles run side by side and are also compared against each other in every cycle. This covers single-cycle pulses, long levels and random trains, with a reset given mid-run.

// File: rtl/pdiv_pkg.sv
package pdiv_pkg;
  typedef enum logic [1:0] {
    STYLE_UP   = 2'd0,
    STYLE_DOWN = 2'd1,
    STYLE_SIGN = 2'd2
  } count_style_e;
endpackage

// File: rtl/pdiv_sync.sv
module pdiv_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic sync_out
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], async_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/pdiv_edge.sv
module pdiv_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic level_in,
  output logic rise_out
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= level_in;
  end

  assign rise_out = level_in & ~prev_q;

  // a rise needs a low sample in between, so two in a row cannot occur
  AST_RISE_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    rise_out |=> !rise_out); // R2
endmodule

// File: rtl/pdiv_count.sv
module pdiv_count
  import pdiv_pkg::*;
#(
  parameter int           DIV_N = 5,
  parameter count_style_e STYLE = STYLE_SIGN
) (
  input  logic clk,
  input  logic rst_n,
  input  logic step,
  output logic terminal
);
  localparam int UW = $clog2(DIV_N + 1);
  localparam int SW = $clog2(DIV_N) + 1;

  generate
    if (STYLE == STYLE_UP) begin : g_up
      localparam logic [UW-1:0] LIMIT = UW'(DIV_N);
      logic [UW-1:0] cnt_q, cnt_d, cnt_inc;
      logic          hit;
      always_comb begin
        cnt_inc = cnt_q + UW'(1);
        hit     = (cnt_inc == LIMIT);
        cnt_d   = cnt_q;
        if (step) cnt_d = hit ? '0 : cnt_inc;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
      end
      assign terminal = step & hit;
      AST_UP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < LIMIT); // R5
      AST_UP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(cnt_q)); // R2
    end else if (STYLE == STYLE_DOWN) begin : g_down
      localparam logic [UW-1:0] LOAD = UW'(DIV_N);
      logic [UW-1:0] cnt_q, cnt_d, cnt_dec;
      logic          hit;
      always_comb begin
        cnt_dec = cnt_q - UW'(1);
        hit     = (cnt_dec == '0);
        cnt_d   = cnt_q;
        if (step) cnt_d = hit ? LOAD : cnt_dec;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= LOAD;
        else        cnt_q <= cnt_d;
      end
      assign terminal = step & hit;
      AST_DOWN_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != '0) && (cnt_q <= LOAD)); // R6
      AST_DOWN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(cnt_q)); // R2
    end else begin : g_sign
      localparam logic [SW-1:0] LOAD = SW'(DIV_N - 1);
      logic [SW-1:0] cnt_q, cnt_d, cnt_dec;
      always_comb begin
        cnt_dec = cnt_q - SW'(1);
        cnt_d   = cnt_q;
        if (step) cnt_d = cnt_dec[SW-1] ? LOAD : cnt_dec;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= LOAD;
        else        cnt_q <= cnt_d;
      end
      assign terminal = step & cnt_dec[SW-1];
      AST_SIGN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_q[SW-1]); // R7
      AST_SIGN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(cnt_q)); // R2
    end
  endgenerate
endmodule

// File: rtl/pulse_divider.sv
module pulse_divider
  import pdiv_pkg::*;
#(
  parameter int           DIV_N       = 5,
  parameter count_style_e STYLE       = STYLE_SIGN,
  parameter int           SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pulse_in,
  output logic div_pulse
);
  generate
    if (DIV_N < 2) begin : g_bad_ratio
      $fatal(1, "pulse_divider: DIV_N must be 2 or more"); // R9
    end
  endgenerate

  logic in_sync;
  logic in_rise;
  logic term;
  logic pulse_q, pulse_d;

  pdiv_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .async_in(pulse_in), .sync_out(in_sync));

  pdiv_edge edge_i (
    .clk(clk), .rst_n(rst_n), .level_in(in_sync), .rise_out(in_rise));

  pdiv_count #(.DIV_N(DIV_N), .STYLE(STYLE)) count_i (
    .clk(clk), .rst_n(rst_n), .step(in_rise), .terminal(term));

  always_comb pulse_d = term;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulse_q <= 1'b0;
    else        pulse_q <= pulse_d;
  end

  assign div_pulse = pulse_q;

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    div_pulse |=> !div_pulse); // R3
  AST_PULSE_FROM_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    div_pulse |-> $past(in_rise)); // R2
endmodule

// File: tb/pulse_divider_tb_top.sv
`timescale 1ns/1ps
module pulse_divider_tb_top;
  import pdiv_pkg::*;
  localparam int N = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pin = 1'b0;
  logic out_up, out_dn, out_sg;

  int tests = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 1'b0;

  // bench model state
  bit last_in = 1'b0;
  bit [2:0] rise_pipe = '0;
  int rise_cnt = 0;
  int exp_pulses = 0;
  int seen_pulses = 0;

  always #2.5 clk = ~clk;

  pulse_divider #(.DIV_N(N), .STYLE(STYLE_UP))   dut_i    (.clk(clk), .rst_n(rst_n), .pulse_in(pin), .div_pulse(out_up));
  pulse_divider #(.DIV_N(N), .STYLE(STYLE_DOWN)) dut_dn_i (.clk(clk), .rst_n(rst_n), .pulse_in(pin), .div_pulse(out_dn));
  pulse_divider #(.DIV_N(N), .STYLE(STYLE_SIGN)) dut_sg_i (.clk(clk), .rst_n(rst_n), .pulse_in(pin), .div_pulse(out_sg));

  task automatic check(input string req, input logic act, input logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at cycle %0d: got %b expected %b", req, cycles, act, exp);
    end
  endtask

  // one clock: drive at falling edge, model at rising edge, compare at next falling edge
  task automatic step(input bit v);
    bit expv;
    pin = v;
    @(posedge clk);
    rise_pipe = {rise_pipe[1:0], (v & ~last_in)};
    last_in = v;
    expv = 1'b0;
    if (rise_pipe[2]) begin
      rise_cnt++;
      if (rise_cnt % N == 0) begin expv = 1'b1; exp_pulses++; end
    end
    @(negedge clk);
    if (out_up) seen_pulses++;
    check("R5 up style / R3 timing", out_up, expv);
    check("R6 down style", out_dn, expv);
    check("R7 sign style", out_sg, expv);
    check("R8 up vs sign", out_up, out_sg);
    check("R8 down vs sign", out_dn, out_sg);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    pin = 1'b0;
    last_in = 1'b0;
    rise_pipe = '0;
    rise_cnt = 0;
    exp_pulses = 0;
    seen_pulses = 0;
    repeat (3) @(negedge clk);
    check("R1 reset up", out_up, 1'b0);
    check("R1 reset down", out_dn, 1'b0);
    check("R1 reset sign", out_sg, 1'b0);
    rst_n = 1'b1;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      fails++;
      $display("FAIL watchdog expired after %0d cycles", cycles);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    // R9 is an elaboration check and cannot be exercised at run time
    do_reset();
    // single-cycle pulses, densest legal rate; R1: first pulse after N edges
    for (int i = 0; i < 4 * N; i++) begin step(1'b1); step(1'b0); end
    repeat (4) step(1'b0);
    tests++;
    if (seen_pulses != 4 || exp_pulses != 4) begin
      fails++;
      $display("FAIL R4 dense train: got %0d expected 4", seen_pulses);
    end
    // long levels: R2, highs and lows held do not advance count
    for (int i = 0; i < 3 * N; i++) begin
      repeat (7) step(1'b1);
      repeat (4) step(1'b0);
    end
    // sweep of high/low lengths
    for (int h = 1; h <= 4; h++)
      for (int l = 1; l <= 4; l++)
        for (int r = 0; r < N + 1; r++) begin
          repeat (h) step(1'b1);
          repeat (l) step(1'b0);
        end
    // mid-count reset: partial count discarded (R1)
    repeat (N - 2) begin step(1'b1); step(1'b0); end
    do_reset();
    for (int i = 0; i < N - 1; i++) begin step(1'b1); step(1'b0); end
    repeat (4) step(1'b0);
    tests++;
    if (seen_pulses != 0) begin
      fails++;
      $display("FAIL R1 pulse before N edges after reset: got %0d expected 0", seen_pulses);
    end
    step(1'b1); step(1'b0);
    repeat (4) step(1'b0);
    tests++;
    if (seen_pulses != 1) begin
      fails++;
      $display("FAIL R1 first pulse after N edges: got %0d expected 1", seen_pulses);
    end
    // random train
    for (int i = 0; i < 4000; i++) step(1'($urandom_range(0, 1)));
    repeat (4) step(1'b0);
    tests++;
    if (seen_pulses != rise_cnt / N) begin
      fails++;
      $display("FAIL R4 random train: got %0d expected %0d", seen_pulses, rise_cnt / N);
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule